// File: doc/BRIEF.md
# Three-Bus ALU Fetch Datapath

This block is the register-and-bus core of a small processor. Two operand buses feed a two-input ALU, and the ALU drives a single result bus. The block holds a program counter, a memory address register, a memory buffer register, an instruction register and a fixed constant of one. It makes no decisions of its own. An external sequencer drives one strobe per bus source, one strobe per ALU operation, one write-enable per destination and a read request. Every cycle carries out exactly the transfer those strobes describe.

Data never moves straight from one register to another. A value is placed on an operand bus and passed through the ALU onto the result bus. A destination register then captures it at the rising clock edge. The program counter is advanced by adding the constant-one source to it; the ALU has no increment operation. Instruction fetch takes three cycles:
- Cycle one copies PC into MAR and issues a read.
- Cycle two writes PC+1 back into PC.
- Cycle three moves the returned word from MBR into IR.

Top module: `tribus_datapath`

## Requirements
- R1: While `rst_n` is low at a rising edge, PC, MAR, MBR and IR are cleared to zero, `mem_rd` goes low and `bus_conflict` goes low.
- R2: With only `alu_pass1` asserted, `res_bus` equals operand bus one. That bus carries PC when `src_pc_b1` is high and zero otherwise.
- R3: With only `alu_pass2` asserted, `res_bus` equals operand bus two. That bus carries the OR of the enabled sources: the constant 1 and MBR. It is zero when neither is enabled.
- R4: With only `alu_sum` asserted, `res_bus` is operand one plus operand two, modulo 2^W. PC plus the constant one, written back to PC, wraps from all ones to zero.
- R5: With no ALU operation asserted, `res_bus` is zero, whatever the source enables are.
- R6: With more than one ALU operation asserted, `op_err` is high in that same cycle and `res_bus` is zero.
- R7: At a rising edge, `wr_mar`, `wr_pc` and `wr_ir` each load `res_bus` into their register. A register whose enable is low keeps its value.
- R8: A read request sampled at an edge raises `mem_rd` for the next cycle. At the end of that cycle, MBR captures `mem_rdata`, which is the word at `mem_addr`. `mem_addr` always shows MAR.
- R9: Enabling both sources of operand bus two in one cycle sets `bus_conflict` at the next edge. The flag stays set until reset.
- R10: Asserting more than one destination write-enable in one cycle also sets `bus_conflict`. Every enabled register still loads.
- R11: The three-step fetch leaves the fetched word in IR, the old PC in MAR and the old PC plus one in PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pc_b1 | input | 1 | PC drives operand bus one |
| src_one_b2 | input | 1 | Constant one drives operand bus two |
| src_mbr_b2 | input | 1 | MBR drives operand bus two |
| alu_pass1 | input | 1 | ALU copies operand one to result bus |
| alu_pass2 | input | 1 | ALU copies operand two to result bus |
| alu_sum | input | 1 | ALU adds both operands |
| wr_mar | input | 1 | MAR loads result bus |
| wr_pc | input | 1 | PC loads result bus |
| wr_ir | input | 1 | IR loads result bus |
| rd_req | input | 1 | Start a memory read |
| mem_rdata | input | W | Read data from memory |
| mem_rd | output | 1 | Read in progress this cycle |
| mem_addr | output | W | Memory address (MAR) |
| pc_q | output | W | Program counter |
| mbr_q | output | W | Memory buffer register |
| ir_q | output | W | Instruction register |
| res_bus | output | W | ALU result bus |
| op_err | output | 1 | More than one ALU operation requested |
| bus_conflict | output | 1 | Sticky source or destination conflict |

## Verification
Every register is visible at the ports, so a wrong transfer shows up one edge after the cycle that caused it. The bad value appears on `pc_q`, `mem_addr`, `mbr_q` or `ir_q`. A wrong operand selection or ALU operation is visible on `res_bus` and `op_err` within the same cycle, before any edge. A read-return fault shows in MBR one cycle later, and in IR at the third fetch step. A missed or spurious conflict shows on `bus_conflict` after the next edge. Running consecutive fetches through a memory with distinct words makes the PC wrap and any stale data observable.

// File: rtl/tribus_pkg.sv
// Shared definitions for the three-bus datapath.
// Assumes the ALU operation strobes are bundled in the order given by alu_op_e.
package tribus_pkg;

    // Bit index of each ALU operation inside the operation vector.
    typedef enum int unsigned {
        OP_PASS1 = 0,
        OP_PASS2 = 1,
        OP_SUM   = 2
    } alu_op_e;

    localparam int unsigned NUM_OPS = 3;

    // Number of destination registers fed from the result bus.
    localparam int unsigned NUM_DST = 3;

endpackage

// File: rtl/tribus_bus_drive.sv
// Operand bus driver.
// Combines N enabled sources onto one bus as a wired OR; an undriven bus reads zero.
// Also reports when more than one source is enabled in the same cycle.
// Assumes src[i] is valid whenever en[i] is high.
module tribus_bus_drive #(
    parameter int unsigned W = 16,
    parameter int unsigned N = 2
) (
    input  logic [N-1:0]        en,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus,
    output logic                multi
);

    logic [N-1:0][W-1:0] gated;

    // Gate each source with its own enable.
    generate
        for (genvar g = 0; g < N; g++) begin : g_gate
            assign gated[g] = en[g] ? src[g] : '0;
        end
    endgenerate

    // OR all gated sources together to form the bus value.
    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | gated[i];
        end
    end

    // Flag more than one enabled source.
    always_comb begin
        multi = ($countones(en) > 1);
    end

endmodule

// File: rtl/tribus_alu.sv
// Two-operand ALU with pass-through and add operations.
// The result is zero when no operation is requested and when more than one is
// requested; the latter also raises err. There is no increment operation.
module tribus_alu
    import tribus_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic [NUM_OPS-1:0] op,
    output logic [W-1:0]       y,
    output logic               err
);

    logic [W-1:0] sum;

    // Modulo-2^W adder.
    always_comb begin
        sum = a + b;
    end

    // Detect a request for more than one operation.
    always_comb begin
        err = ($countones(op) > 1);
    end

    // Steer the selected operation onto the result.
    always_comb begin
        y = '0;
        if (!err) begin
            unique case (1'b1)
                op[OP_PASS1]: y = a;
                op[OP_PASS2]: y = b;
                op[OP_SUM]:   y = sum;
                default:      y = '0;
            endcase
        end
    end

endmodule

// File: rtl/tribus_regs.sv
// Register bank of the datapath: PC, MAR, MBR and IR, plus the read-pending bit.
// PC, MAR and IR load the result bus on their write-enables. MBR loads memory read
// data in the cycle after a read request. Synchronous active-low reset.
module tribus_regs #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] res,
    input  logic         ld_mar,
    input  logic         ld_pc,
    input  logic         ld_ir,
    input  logic         rd_req,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] pc,
    output logic [W-1:0] mar,
    output logic [W-1:0] mbr,
    output logic [W-1:0] ir,
    output logic         rd_pend
);

    // Program counter: loads the result bus.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc <= '0;
        else if (ld_pc) pc <= res;
    end

    // Memory address register: loads the result bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      mar <= '0;
        else if (ld_mar) mar <= res;
    end

    // Instruction register: loads the result bus.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir <= '0;
        else if (ld_ir) ir <= res;
    end

    // Read-pending flag: marks the cycle in which memory returns data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_pend <= 1'b0;
        else        rd_pend <= rd_req;
    end

    // Memory buffer register: captures read data at the end of the pending cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       mbr <= '0;
        else if (rd_pend) mbr <= rdata;
    end

endmodule

// File: rtl/tribus_datapath.sv
// Three-bus fetch datapath, top level.
// PC drives operand bus one. The constant one and MBR drive operand bus two.
// The ALU drives the result bus, which feeds MAR, PC and IR. MBR is filled by
// memory one cycle after a read request. Conflicts on bus two and multiple
// destination writes set a sticky flag. Control strobes come from outside.
module tribus_datapath
    import tribus_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_pc_b1,
    input  logic         src_one_b2,
    input  logic         src_mbr_b2,
    input  logic         alu_pass1,
    input  logic         alu_pass2,
    input  logic         alu_sum,
    input  logic         wr_mar,
    input  logic         wr_pc,
    input  logic         wr_ir,
    input  logic         rd_req,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_rd,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] pc_q,
    output logic [W-1:0] mbr_q,
    output logic [W-1:0] ir_q,
    output logic [W-1:0] res_bus,
    output logic         op_err,
    output logic         bus_conflict
);

    localparam logic [W-1:0] ONE_VAL = W'(1);

    logic [W-1:0]          pc_r, mar_r, mbr_r, ir_r;
    logic [W-1:0]          b1, b2, b3;
    logic                  b1_multi, b2_multi;
    logic                  alu_err;
    logic                  rd_pend;
    logic [NUM_OPS-1:0]    ops;
    logic [NUM_DST-1:0]    dst_we;
    logic                  conflict_q;

    // Bundle the operation strobes in package order.
    always_comb begin
        ops           = '0;
        ops[OP_PASS1] = alu_pass1;
        ops[OP_PASS2] = alu_pass2;
        ops[OP_SUM]   = alu_sum;
    end

    // Bundle the destination write-enables.
    always_comb begin
        dst_we = {wr_ir, wr_pc, wr_mar};
    end

    // Operand bus one: PC is its only source.
    tribus_bus_drive #(.W(W), .N(1)) u_b1 (
        .en    (src_pc_b1),
        .src   (pc_r),
        .bus   (b1),
        .multi (b1_multi)
    );

    // Operand bus two: index 0 is the constant one, index 1 is MBR.
    tribus_bus_drive #(.W(W), .N(2)) u_b2 (
        .en    ({src_mbr_b2, src_one_b2}),
        .src   ({mbr_r, ONE_VAL}),
        .bus   (b2),
        .multi (b2_multi)
    );

    tribus_alu #(.W(W)) u_alu (
        .a   (b1),
        .b   (b2),
        .op  (ops),
        .y   (b3),
        .err (alu_err)
    );

    tribus_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .res     (b3),
        .ld_mar  (wr_mar),
        .ld_pc   (wr_pc),
        .ld_ir   (wr_ir),
        .rd_req  (rd_req),
        .rdata   (mem_rdata),
        .pc      (pc_r),
        .mar     (mar_r),
        .mbr     (mbr_r),
        .ir      (ir_r),
        .rd_pend (rd_pend)
    );

    // Sticky conflict flag: set by any source or destination conflict, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            conflict_q <= 1'b0;
        else if (b1_multi || b2_multi || ($countones(dst_we) > 1))
            conflict_q <= 1'b1;
    end

    // Drive the outputs.
    always_comb begin
        mem_rd       = rd_pend;
        mem_addr     = mar_r;
        pc_q         = pc_r;
        mbr_q        = mbr_r;
        ir_q         = ir_r;
        res_bus      = b3;
        op_err       = alu_err;
        bus_conflict = conflict_q;
    end

endmodule

// File: rtl/tribus_datapath_chk.sv
// Port-level protocol checker for tribus_datapath, attached by bind.
// Observes inputs and outputs only.
module tribus_datapath_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         src_pc_b1,
    input logic         src_one_b2,
    input logic         src_mbr_b2,
    input logic         alu_pass1,
    input logic         alu_pass2,
    input logic         alu_sum,
    input logic         wr_mar,
    input logic         wr_pc,
    input logic         wr_ir,
    input logic         rd_req,
    input logic [W-1:0] mem_rdata,
    input logic         mem_rd,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] pc_q,
    input logic [W-1:0] mbr_q,
    input logic [W-1:0] ir_q,
    input logic [W-1:0] res_bus,
    input logic         op_err,
    input logic         bus_conflict
);

    logic [W-1:0] opnd1, opnd2;
    logic [2:0]   opv;

    // Operand values implied by the port-level source enables.
    always_comb begin
        opnd1 = src_pc_b1 ? pc_q : '0;
        opnd2 = (src_one_b2 ? W'(1) : '0) | (src_mbr_b2 ? mbr_q : '0);
        opv   = {alu_sum, alu_pass2, alu_pass1};
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && mem_addr == '0 && mbr_q == '0 && ir_q == '0 && !mem_rd && !bus_conflict)); // R1

    AST_PASS1_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (opv == 3'b001) |-> (res_bus == opnd1)); // R2

    AST_PASS2_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (opv == 3'b010) |-> (res_bus == opnd2)); // R3

    AST_SUM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (opv == 3'b100) |-> (res_bus == W'(opnd1 + opnd2))); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (opv == 3'b000) |-> (res_bus == '0 && !op_err)); // R5

    AST_MULTI_OP: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(opv) > 1) |-> (op_err && res_bus == '0)); // R6

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pc |=> (pc_q == $past(res_bus))); // R7

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pc |=> $stable(pc_q)); // R7

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ir |=> $stable(ir_q)); // R7

    AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> mem_rd); // R8

    AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mbr_q == $past(mem_rdata))); // R8

    AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (src_one_b2 && src_mbr_b2) |=> bus_conflict); // R9

    AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_conflict |=> bus_conflict); // R9

    AST_DEST_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({wr_mar, wr_pc, wr_ir}) > 1) |=> bus_conflict); // R10

endmodule

bind tribus_datapath tribus_datapath_chk #(.W(W)) u_chk (.*);

// File: tb/tribus_datapath_test.sv
// Scoreboard bench: a driver task applies one cycle of strobes and pushes the
// expected register state. A monitor pops each item after the edge and compares.
module tribus_datapath_test;

    localparam int unsigned W = 16;

    localparam logic [9:0] C_PC1  = 10'h001;
    localparam logic [9:0] C_ONE  = 10'h002;
    localparam logic [9:0] C_MBR  = 10'h004;
    localparam logic [9:0] C_P1   = 10'h008;
    localparam logic [9:0] C_P2   = 10'h010;
    localparam logic [9:0] C_SUM  = 10'h020;
    localparam logic [9:0] C_LMAR = 10'h040;
    localparam logic [9:0] C_LPC  = 10'h080;
    localparam logic [9:0] C_LIR  = 10'h100;
    localparam logic [9:0] C_RD   = 10'h200;

    typedef struct {
        logic [W-1:0] pc;
        logic [W-1:0] mar;
        logic [W-1:0] mbr;
        logic [W-1:0] ir;
        logic         rd;
        logic         conf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [9:0]   ctl = '0;
    logic [W-1:0] mem_rdata;
    logic         mem_rd;
    logic [W-1:0] mem_addr, pc_q, mbr_q, ir_q, res_bus;
    logic         op_err, bus_conflict;

    logic [W-1:0] mem [0:15];
    exp_t         q [$];
    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] m_pc, m_mar, m_mbr, m_ir;
    logic         m_rd, m_conf;

    always #2.5 clk = ~clk;

    // Memory model: returns the word at the current address.
    assign mem_rdata = mem[mem_addr[3:0]];

    tribus_datapath #(.W(W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_pc_b1    (ctl[0]),
        .src_one_b2   (ctl[1]),
        .src_mbr_b2   (ctl[2]),
        .alu_pass1    (ctl[3]),
        .alu_pass2    (ctl[4]),
        .alu_sum      (ctl[5]),
        .wr_mar       (ctl[6]),
        .wr_pc        (ctl[7]),
        .wr_ir        (ctl[8]),
        .rd_req       (ctl[9]),
        .mem_rdata    (mem_rdata),
        .mem_rd       (mem_rd),
        .mem_addr     (mem_addr),
        .pc_q         (pc_q),
        .mbr_q        (mbr_q),
        .ir_q         (ir_q),
        .res_bus      (res_bus),
        .op_err       (op_err),
        .bus_conflict (bus_conflict)
    );

    task automatic chk(input string tag, input string fld, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    task automatic push_state(input string tag);
        exp_t e;
        e.pc = m_pc; e.mar = m_mar; e.mbr = m_mbr; e.ir = m_ir;
        e.rd = m_rd; e.conf = m_conf; e.tag = tag;
        q.push_back(e);
    endtask

    // Hold reset for one edge and expect the cleared state (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctl   = '0;
        m_pc = '0; m_mar = '0; m_mbr = '0; m_ir = '0; m_rd = 1'b0; m_conf = 1'b0;
        push_state("R1 reset");
    endtask

    // Apply one cycle of strobes, check the result bus, predict the next state.
    task automatic cyc(input logic [9:0] c, input string tag);
        logic [W-1:0] b1, b2, b3, old_mar;
        int nops, nld;
        @(negedge clk);
        rst_n = 1'b1;
        ctl   = c;
        b1   = c[0] ? m_pc : '0;
        b2   = (c[1] ? W'(1) : '0) | (c[2] ? m_mbr : '0);
        nops = int'(c[3]) + int'(c[4]) + int'(c[5]);
        nld  = int'(c[6]) + int'(c[7]) + int'(c[8]);
        if (nops != 1)  b3 = '0;
        else if (c[5])  b3 = b1 + b2;
        else if (c[3])  b3 = b1;
        else            b3 = b2;
        #1;
        chk(tag, "res_bus", res_bus, b3);
        chk(tag, "op_err", W'(op_err), W'(nops > 1));
        old_mar = m_mar;
        if (c[6]) m_mar = b3;
        if (c[7]) m_pc  = b3;
        if (c[8]) m_ir  = b3;
        if (m_rd) m_mbr = mem[old_mar[3:0]];
        m_rd = c[9];
        if ((c[1] && c[2]) || nld > 1) m_conf = 1'b1;
        push_state(tag);
    endtask

    task automatic fetch(input string tag);
        cyc(C_PC1 | C_P1 | C_LMAR | C_RD, {tag, " R2/R8 T0"});
        cyc(C_PC1 | C_ONE | C_SUM | C_LPC, {tag, " R4/R8 T1"});
        cyc(C_MBR | C_P2 | C_LIR, {tag, " R3/R11 T2"});
    endtask

    // Monitor: after each edge, compare the oldest expected item.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "pc", pc_q, e.pc);
            chk(e.tag, "mar", mem_addr, e.mar);
            chk(e.tag, "mbr", mbr_q, e.mbr);
            chk(e.tag, "ir", ir_q, e.ir);
            chk(e.tag, "mem_rd", W'(mem_rd), W'(e.rd));
            chk(e.tag, "bus_conflict", W'(bus_conflict), W'(e.conf));
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 50000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'hA000 + 16'(i) * 16'h0111;
        mem[1] = 16'h0005;
        mem[5] = 16'hFFFF;

        do_reset();
        fetch("R11 fetch0");
        fetch("R11 fetch1");
        cyc(C_MBR | C_P2 | C_LPC, "R3/R7 mbr to pc");
        cyc(C_PC1, "R5 no op");
        cyc('0, "R7 hold");
        fetch("R11 fetch5");
        cyc(C_MBR | C_P2 | C_LPC, "R3 max to pc");
        cyc(C_PC1 | C_ONE | C_SUM | C_LPC, "R4 wrap");
        cyc(C_PC1 | C_ONE | C_P1 | C_SUM | C_LMAR, "R6 two ops");
        cyc(C_P1 | C_P2 | C_SUM, "R6 three ops");
        cyc(C_ONE | C_MBR | C_P2 | C_LIR, "R9 b2 conflict");
        cyc('0, "R9 sticky");
        cyc(C_PC1 | C_P1, "R9 sticky2");
        do_reset();
        cyc(C_PC1 | C_ONE | C_SUM | C_LMAR | C_LPC, "R10 two dests");
        cyc('0, "R10 sticky");
        do_reset();
        fetch("R11 after reset");

        @(negedge clk);
        ctl = '0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule